// File: doc/BRIEF.md
# Pipeline Control State Machine

This block is the sequencing core of a small pipelined soft processor. Each cycle it looks at the opcode class of the instructions in the operand and execute stages, and at the state of memory and instruction prefetch. From these it decides whether the pipeline advances, whether the instruction in execute commits and writes the register file, and whether a memory read or write is requested. It also decides when the prefetch buffer or the whole pipeline is flushed. The ALU, register file, prefetch storage and memory are outside the block. They reach it only through the class codes, the forwarded flags and register operand, the memory wait and read-data lines, and the prefetch-empty flag.

There are five states. `ST_RUN` is run-and-execute. `ST_LDW` waits out a slow load and `ST_STW` a slow store. `ST_CHK` is the skip shadow, where nothing commits. `ST_TRAP` fetches a trap vector.

The transitions are:
- **ld_stall** and **st_stall** go from `ST_RUN` to `ST_LDW` or `ST_STW` when memory is waiting.
- **mem_done** goes from either wait state back to `ST_RUN` when the wait ends.
- **skip_hit** goes from `ST_RUN` to `ST_CHK` on a taken skip.
- **prefix_hold** keeps the block in `ST_CHK`.
- **shadow_end** goes from `ST_CHK` back to `ST_RUN`.
- **trap_enter** goes from `ST_RUN` to `ST_TRAP`.
- **vector_ready** goes from `ST_TRAP` back to `ST_RUN`.

Interrupts are accepted by injecting a trap with the request's number into the pipeline.

Top module: `ctl_fsm`

## Requirements
- R1: While `rst` is high, every output is 0. The state after reset is `ST_RUN`.
- R2: In `ST_RUN` with prefetch not empty, an instruction in execute commits (`commit_en`=1, `stall`=0). `rf_we` is 1 only for ALU (class 1) and load (class 2). A load (class 2) raises `mem_rd`. With `mem_wait`=0 the load completes in that cycle and the state stays `ST_RUN`.
- R3: A load that sees `mem_wait`=1 enters `ST_LDW`. There `mem_rd` and `stall` stay 1 and `commit_en` stays 0 while `mem_wait` is 1. In the cycle `mem_wait` is 0, `commit_en` and `rf_we` are 1 and the state returns to `ST_RUN`.
- R4: A store (class 3) behaves like R2 and R3 but raises `mem_wr` instead of `mem_rd`, never raises `rf_we`, and waits in `ST_STW`. `mem_rd` and `mem_wr` are never both 1.
- R5: A skip (class 4) is evaluated in execute from `ex_skip_kind`:
  - 0: taken when `flags & ex_flag_mask` is nonzero.
  - 1: taken when `reg_opnd`==0.
  - 2: taken when `reg_opnd`!=0.
  - 3: taken when bit `ex_bit_sel` of `reg_opnd` is 1.
  - 4: taken when that bit is 0.
  - 5 to 7: never taken.

  The skip itself commits. When it is taken the state goes to `ST_CHK`; otherwise the next instruction commits.
- R6: In `ST_CHK`, `commit_en` and `rf_we` are 0 and no memory request is made. The state stays `ST_CHK` while execute holds a prefix (class 5) or prefetch is empty. It returns to `ST_RUN` once a non-prefix instruction passes execute.
- R7: A trap (class 7) in execute in `ST_RUN` raises `mem_rd` and `vec_sel`, with `vec_addr` = `VEC_BASE` + 4×`ex_trap_num`, and enters `ST_TRAP`. In `ST_TRAP` the block stalls and holds `mem_rd` and the same `vec_addr` while `mem_wait` is 1. When `mem_wait` is 0 it raises `pf_flush`, `pipe_flush` and `fetch_redirect` with `fetch_pc`=`mem_rdata`, and returns to `ST_RUN`.
- R8: In `ST_RUN`, a control-flow instruction (class 6) in the operand stage raises `pf_flush` in the same cycle. It does not do so when the cycle stalls or when a skip in execute is taken.
- R9: In `ST_RUN` with `pf_empty`=1, `stall` is 1, `commit_en` is 0, no request is made and the state stays `ST_RUN`.
- R10: In `ST_LDW` or `ST_STW`, an operand-stage control-flow instruction raises `pf_flush` only in the cycle `mem_wait` is 0. In `ST_TRAP`, or with a trap in execute, it causes no flush of its own.
- R11: With `irq_req`=1 in a non-stalled `ST_RUN` cycle, `inject_trap` is 1 and `inject_num`=`irq_num`, and `squash_young`=`irq_sw`. In every other cycle all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| od_class | input | 3 | opcode class in operand stage |
| ex_class | input | 3 | opcode class in execute stage |
| ex_skip_kind | input | 3 | skip condition selector |
| ex_flag_mask | input | FLAG_W | flags tested by flag skip |
| flags | input | FLAG_W | forwarded condition flags |
| reg_opnd | input | DATA_W | forwarded register operand |
| ex_bit_sel | input | BIT_W | bit index for bit skips |
| ex_trap_num | input | TNUM_W | trap number of trap in execute |
| mem_wait | input | 1 | memory not ready |
| mem_rdata | input | ADDR_W | memory read data (vector) |
| pf_empty | input | 1 | prefetch has no next instruction |
| irq_req | input | 1 | interrupt request |
| irq_sw | input | 1 | request is a software interrupt |
| irq_num | input | TNUM_W | interrupt number |
| stall | output | 1 | hold pipeline |
| commit_en | output | 1 | execute instruction commits |
| rf_we | output | 1 | register file write |
| pf_flush | output | 1 | flush prefetch unit |
| pipe_flush | output | 1 | flush pipeline registers |
| mem_rd | output | 1 | memory read request |
| mem_wr | output | 1 | memory write request |
| vec_sel | output | 1 | memory address is the trap vector |
| vec_addr | output | ADDR_W | vector table entry address |
| fetch_redirect | output | 1 | load fetch address |
| fetch_pc | output | ADDR_W | new fetch address |
| inject_trap | output | 1 | insert trap into pipeline |
| inject_num | output | TNUM_W | number of injected trap |
| squash_young | output | 1 | replace younger instructions with NOPs |

## Verification
The bench drives a prefix chain behind a taken skip to check the first non-prefix instruction. A design that leaves the shadow one cycle early lets that instruction commit, and one that leaves it late drops the next instruction's commit. It puts a control-flow instruction in the operand stage during a load wait, a trap vector fetch and a taken skip. A wrong design flushes prefetch too early or obeys a control flow that must be ignored. Each skip kind is hit on both sides of its condition, including bit tests at the edge bits. Random traffic mixes prefetch-empty stalls and interrupt requests so that injection during a stall, or a vector address that drifts while memory waits, shows up as a mismatch.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    typedef enum logic [2:0] {
        OC_NOP    = 3'd0,
        OC_ALU    = 3'd1,
        OC_LOAD   = 3'd2,
        OC_STORE  = 3'd3,
        OC_SKIP   = 3'd4,
        OC_PREFIX = 3'd5,
        OC_CFLOW  = 3'd6,
        OC_TRAP   = 3'd7
    } op_class_e;

    typedef enum logic [2:0] {
        SK_FLAG    = 3'd0,
        SK_ZERO    = 3'd1,
        SK_NONZERO = 3'd2,
        SK_BITSET  = 3'd3,
        SK_BITCLR  = 3'd4
    } skip_kind_e;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_LDW  = 3'd1,
        ST_STW  = 3'd2,
        ST_CHK  = 3'd3,
        ST_TRAP = 3'd4
    } ctl_state_e;
endpackage

// File: rtl/skip_eval.sv
module skip_eval #(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 4,
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic [2:0]        kind,
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] mask,
    input  logic [DATA_W-1:0] opnd,
    input  logic [BIT_W-1:0]  bit_sel,
    output logic              taken
);
    import ctl_pkg::*;

    logic sel_bit;
    assign sel_bit = opnd[bit_sel];

    always_comb begin
        case (kind)
            SK_FLAG:    taken = |(flags & mask);
            SK_ZERO:    taken = (opnd == '0);
            SK_NONZERO: taken = (opnd != '0);
            SK_BITSET:  taken = sel_bit;
            SK_BITCLR:  taken = !sel_bit;
            default:    taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
    parameter int              ADDR_W   = 32,
    parameter int              TNUM_W   = 5,
    parameter logic [ADDR_W-1:0] VEC_BASE = 'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              use_held,
    input  logic [TNUM_W-1:0] num_in,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - TNUM_W;

    logic [TNUM_W-1:0] held;
    logic [TNUM_W-1:0] num;

    always_ff @(posedge clk) begin
        if (rst)          held <= '0;
        else if (capture) held <= num_in;
    end

    assign num  = use_held ? held : num_in;
    assign addr = VEC_BASE + ({{PAD_W{1'b0}}, num} << 2);
endmodule

// File: rtl/ctl_fsm.sv
module ctl_fsm #(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 32,
    parameter int                FLAG_W   = 4,
    parameter int                TNUM_W   = 5,
    parameter logic [ADDR_W-1:0] VEC_BASE = 'h100,
    parameter int                BIT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        od_class,
    input  logic [2:0]        ex_class,
    input  logic [2:0]        ex_skip_kind,
    input  logic [FLAG_W-1:0] ex_flag_mask,
    input  logic [FLAG_W-1:0] flags,
    input  logic [DATA_W-1:0] reg_opnd,
    input  logic [BIT_W-1:0]  ex_bit_sel,
    input  logic [TNUM_W-1:0] ex_trap_num,
    input  logic              mem_wait,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              pf_empty,
    input  logic              irq_req,
    input  logic              irq_sw,
    input  logic [TNUM_W-1:0] irq_num,
    output logic              stall,
    output logic              commit_en,
    output logic              rf_we,
    output logic              pf_flush,
    output logic              pipe_flush,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              vec_sel,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              fetch_redirect,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              inject_trap,
    output logic [TNUM_W-1:0] inject_num,
    output logic              squash_young
);
    import ctl_pkg::*;

    ctl_state_e state, state_nx;
    op_class_e  ex_c, od_c;
    logic       skip_hit, od_cf, trap_cap;
    logic [ADDR_W-1:0] vaddr_raw;

    assign ex_c  = op_class_e'(ex_class);
    assign od_c  = op_class_e'(od_class);
    assign od_cf = (od_c == OC_CFLOW);

    skip_eval #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .BIT_W(BIT_W)) u_skip (
        .kind(ex_skip_kind), .flags(flags), .mask(ex_flag_mask),
        .opnd(reg_opnd), .bit_sel(ex_bit_sel), .taken(skip_hit)
    );

    assign trap_cap = !rst && (state == ST_RUN) && !pf_empty && (ex_c == OC_TRAP);

    trap_vec #(.ADDR_W(ADDR_W), .TNUM_W(TNUM_W), .VEC_BASE(VEC_BASE)) u_vec (
        .clk(clk), .rst(rst), .capture(trap_cap), .use_held(state == ST_TRAP),
        .num_in(ex_trap_num), .addr(vaddr_raw)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    // outputs and next state
    always_comb begin
        state_nx       = state;
        stall          = 1'b0;
        commit_en      = 1'b0;
        rf_we          = 1'b0;
        pf_flush       = 1'b0;
        pipe_flush     = 1'b0;
        mem_rd         = 1'b0;
        mem_wr         = 1'b0;
        vec_sel        = 1'b0;
        fetch_redirect = 1'b0;
        fetch_pc       = '0;
        inject_trap    = 1'b0;
        inject_num     = '0;
        squash_young   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (pf_empty) begin
                    stall = 1'b1;
                end else begin
                    unique case (ex_c)
                        OC_LOAD: begin
                            mem_rd = 1'b1;
                            if (mem_wait) begin
                                stall    = 1'b1;
                                state_nx = ST_LDW;
                            end else begin
                                commit_en = 1'b1;
                                rf_we     = 1'b1;
                            end
                        end
                        OC_STORE: begin
                            mem_wr = 1'b1;
                            if (mem_wait) begin
                                stall    = 1'b1;
                                state_nx = ST_STW;
                            end else begin
                                commit_en = 1'b1;
                            end
                        end
                        OC_TRAP: begin
                            mem_rd   = 1'b1;
                            vec_sel  = 1'b1;
                            stall    = 1'b1;
                            state_nx = ST_TRAP;
                        end
                        OC_SKIP: begin
                            commit_en = 1'b1;
                            if (skip_hit) state_nx = ST_CHK;
                        end
                        OC_ALU: begin
                            commit_en = 1'b1;
                            rf_we     = 1'b1;
                        end
                        default: commit_en = 1'b1;
                    endcase
                    pf_flush = od_cf && !stall && !((ex_c == OC_SKIP) && skip_hit);
                    if (irq_req && !stall) begin
                        inject_trap  = 1'b1;
                        inject_num   = irq_num;
                        squash_young = irq_sw;
                    end
                end
            end
            ST_LDW, ST_STW: begin
                mem_rd = (state == ST_LDW);
                mem_wr = (state == ST_STW);
                if (mem_wait) begin
                    stall = 1'b1;
                end else begin
                    commit_en = 1'b1;
                    rf_we     = (state == ST_LDW);
                    pf_flush  = od_cf;
                    state_nx  = ST_RUN;
                end
            end
            ST_CHK: begin
                if (pf_empty) begin
                    stall = 1'b1;
                end else if (ex_c != OC_PREFIX) begin
                    pf_flush = od_cf;
                    state_nx = ST_RUN;
                end
            end
            ST_TRAP: begin
                mem_rd  = 1'b1;
                vec_sel = 1'b1;
                if (mem_wait) begin
                    stall = 1'b1;
                end else begin
                    pf_flush       = 1'b1;
                    pipe_flush     = 1'b1;
                    fetch_redirect = 1'b1;
                    fetch_pc       = mem_rdata;
                    state_nx       = ST_RUN;
                end
            end
        endcase
        if (rst) begin
            state_nx       = ST_RUN;
            stall          = 1'b0;
            commit_en      = 1'b0;
            rf_we          = 1'b0;
            pf_flush       = 1'b0;
            pipe_flush     = 1'b0;
            mem_rd         = 1'b0;
            mem_wr         = 1'b0;
            vec_sel        = 1'b0;
            fetch_redirect = 1'b0;
            fetch_pc       = '0;
            inject_trap    = 1'b0;
            inject_num     = '0;
            squash_young   = 1'b0;
        end
    end

    assign vec_addr = vec_sel ? vaddr_raw : '0;

    assert_rf_we_commit_R2: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> commit_en);
    assert_ldw_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LDW && mem_wait) |-> (stall && mem_rd && !commit_en));
    assert_rd_wr_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    assert_shadow_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHK) |-> (!commit_en && !mem_rd && !mem_wr));
    assert_vec_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRAP && mem_wait) |=> $stable(vec_addr));
    assert_flush_pair_R7: assert property (@(posedge clk) disable iff (rst)
        pipe_flush |-> (pf_flush && fetch_redirect));
    assert_inject_run_R11: assert property (@(posedge clk) disable iff (rst)
        inject_trap |-> (state == ST_RUN && !stall));
endmodule

// File: tb/sim_ctl_fsm.sv
module sim_ctl_fsm;
    localparam int          DATA_W   = 32;
    localparam int          ADDR_W   = 32;
    localparam int          FLAG_W   = 4;
    localparam int          TNUM_W   = 5;
    localparam int          BIT_W    = 5;
    localparam logic [31:0] VEC_BASE = 32'h100;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic [2:0] od_class = '0, ex_class = '0, ex_skip_kind = '0;
    logic [FLAG_W-1:0] ex_flag_mask = '0, flags = '0;
    logic [DATA_W-1:0] reg_opnd = '0;
    logic [BIT_W-1:0]  ex_bit_sel = '0;
    logic [TNUM_W-1:0] ex_trap_num = '0, irq_num = '0;
    logic mem_wait = 1'b0, pf_empty = 1'b0, irq_req = 1'b0, irq_sw = 1'b0;
    logic [ADDR_W-1:0] mem_rdata = '0;

    logic stall, commit_en, rf_we, pf_flush, pipe_flush, mem_rd, mem_wr, vec_sel;
    logic fetch_redirect, inject_trap, squash_young;
    logic [ADDR_W-1:0] vec_addr, fetch_pc;
    logic [TNUM_W-1:0] inject_num;

    ctl_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .TNUM_W(TNUM_W),
              .VEC_BASE(VEC_BASE)) u0 (
        .clk(clk), .rst(rst), .od_class(od_class), .ex_class(ex_class),
        .ex_skip_kind(ex_skip_kind), .ex_flag_mask(ex_flag_mask), .flags(flags),
        .reg_opnd(reg_opnd), .ex_bit_sel(ex_bit_sel), .ex_trap_num(ex_trap_num),
        .mem_wait(mem_wait), .mem_rdata(mem_rdata), .pf_empty(pf_empty),
        .irq_req(irq_req), .irq_sw(irq_sw), .irq_num(irq_num),
        .stall(stall), .commit_en(commit_en), .rf_we(rf_we), .pf_flush(pf_flush),
        .pipe_flush(pipe_flush), .mem_rd(mem_rd), .mem_wr(mem_wr), .vec_sel(vec_sel),
        .vec_addr(vec_addr), .fetch_redirect(fetch_redirect), .fetch_pc(fetch_pc),
        .inject_trap(inject_trap), .inject_num(inject_num), .squash_young(squash_young)
    );

    int n_chk = 0, n_bad = 0;

    // bench model state: 0 run, 1 load wait, 2 store wait, 3 shadow, 4 trap
    int m_st = 0;
    logic [TNUM_W-1:0] m_num = '0;

    function automatic logic skip_taken(input logic [2:0] k, input logic [FLAG_W-1:0] f,
                                        input logic [FLAG_W-1:0] m, input logic [DATA_W-1:0] r,
                                        input logic [BIT_W-1:0] b);
        if (k == 3'd0) return (f & m) != 0;
        if (k == 3'd1) return r == 0;
        if (k == 3'd2) return r != 0;
        if (k == 3'd3) return r[b];
        if (k == 3'd4) return !r[b];
        return 1'b0;
    endfunction

    function automatic string area_tag();
        if (rst) return "R1";
        if (m_st == 1) return "R3";
        if (m_st == 2) return "R4";
        if (m_st == 3) return "R6";
        if (m_st == 4) return "R7";
        if (pf_empty) return "R9";
        if (ex_class == 3'd2) return "R2";
        if (ex_class == 3'd3) return "R4";
        if (ex_class == 3'd4) return "R5";
        if (ex_class == 3'd7) return "R7";
        if (irq_req) return "R11";
        return "R8";
    endfunction

    task automatic cmp(input string tag, input string nm, input logic [31:0] a, input logic [31:0] e);
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", tag, nm, a, e, $time);
        end
    endtask

    task automatic step(input string tag);
        logic e_st, e_cm, e_we, e_pf, e_pp, e_rd, e_wr, e_vs, e_fr, e_it, e_sq;
        logic [31:0] e_va, e_fp;
        logic [TNUM_W-1:0] e_in;
        int nx;
        logic tk;
        #1;
        {e_st, e_cm, e_we, e_pf, e_pp, e_rd, e_wr, e_vs, e_fr, e_it, e_sq} = '0;
        e_va = 0; e_fp = 0; e_in = 0;
        nx = m_st;
        tk = skip_taken(ex_skip_kind, flags, ex_flag_mask, reg_opnd, ex_bit_sel);
        if (rst) begin
            nx = 0;
        end else if (m_st == 0) begin
            if (pf_empty) e_st = 1;
            else begin
                case (ex_class)
                    3'd2: begin e_rd = 1; if (mem_wait) begin e_st = 1; nx = 1; end
                                          else begin e_cm = 1; e_we = 1; end end
                    3'd3: begin e_wr = 1; if (mem_wait) begin e_st = 1; nx = 2; end
                                          else e_cm = 1; end
                    3'd7: begin e_rd = 1; e_vs = 1; e_st = 1; nx = 4; m_num = ex_trap_num;
                                e_va = VEC_BASE + 32'(ex_trap_num) * 4; end
                    3'd4: begin e_cm = 1; if (tk) nx = 3; end
                    3'd1: begin e_cm = 1; e_we = 1; end
                    default: e_cm = 1;
                endcase
                e_pf = (od_class == 3'd6) && !e_st && !(ex_class == 3'd4 && tk);
                if (irq_req && !e_st) begin e_it = 1; e_in = irq_num; e_sq = irq_sw; end
            end
        end else if (m_st == 1 || m_st == 2) begin
            e_rd = (m_st == 1); e_wr = (m_st == 2);
            if (mem_wait) e_st = 1;
            else begin e_cm = 1; e_we = (m_st == 1); e_pf = (od_class == 3'd6); nx = 0; end
        end else if (m_st == 3) begin
            if (pf_empty) e_st = 1;
            else if (ex_class != 3'd5) begin e_pf = (od_class == 3'd6); nx = 0; end
        end else begin
            e_rd = 1; e_vs = 1; e_va = VEC_BASE + 32'(m_num) * 4;
            if (mem_wait) e_st = 1;
            else begin e_pf = 1; e_pp = 1; e_fr = 1; e_fp = mem_rdata; nx = 0; end
        end
        n_chk++;
        cmp(tag, "stall", 32'(stall), 32'(e_st));
        cmp(tag, "commit_en", 32'(commit_en), 32'(e_cm));
        cmp(tag, "rf_we", 32'(rf_we), 32'(e_we));
        cmp(tag, "pf_flush", 32'(pf_flush), 32'(e_pf));
        cmp(tag, "pipe_flush", 32'(pipe_flush), 32'(e_pp));
        cmp(tag, "mem_rd", 32'(mem_rd), 32'(e_rd));
        cmp(tag, "mem_wr", 32'(mem_wr), 32'(e_wr));
        cmp(tag, "vec_sel", 32'(vec_sel), 32'(e_vs));
        cmp(tag, "vec_addr", vec_addr, e_va);
        cmp(tag, "fetch_redirect", 32'(fetch_redirect), 32'(e_fr));
        cmp(tag, "fetch_pc", fetch_pc, e_fp);
        cmp(tag, "inject_trap", 32'(inject_trap), 32'(e_it));
        cmp(tag, "inject_num", 32'(inject_num), 32'(e_in));
        cmp(tag, "squash_young", 32'(squash_young), 32'(e_sq));
        m_st = nx;
        @(negedge clk);
    endtask

    task automatic idle();
        rst = 0; od_class = 0; ex_class = 0; mem_wait = 0; pf_empty = 0; irq_req = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        rst = 1; ex_class = 3'd7; od_class = 3'd6; irq_req = 1; step("R1"); step("R1");
        idle(); ex_class = 3'd1; step("R2");
        ex_class = 3'd2; step("R2");                       // zero-latency load
        ex_class = 3'd3; step("R4");                       // zero-latency store
        // R3 load wait, with R10 deferred flush
        ex_class = 3'd2; mem_wait = 1; od_class = 3'd6; step("R3");
        step("R10"); step("R3");
        mem_wait = 0; step("R10");
        idle(); ex_class = 3'd3; mem_wait = 1; step("R4"); step("R4");
        mem_wait = 0; step("R4");
        // R5 every skip kind both ways
        idle();
        for (int k = 0; k < 6; k++) begin
            for (int v = 0; v < 2; v++) begin
                ex_class = 3'd4; ex_skip_kind = 3'(k);
                flags = v ? 4'b0100 : 4'b1010; ex_flag_mask = 4'b0100;
                reg_opnd = v ? 32'h8000_0000 : 32'h0;
                ex_bit_sel = 5'd31;
                step("R5");
                ex_class = 3'd1; step("R5"); step("R5");
            end
        end
        reg_opnd = 32'h1; ex_bit_sel = 0; ex_skip_kind = 3'd4; ex_class = 3'd4; step("R5");
        ex_class = 3'd1; step("R12"); step("R5");
        // R6 prefix chain in the shadow, skipped control flow not flushed (R8)
        ex_class = 3'd4; ex_skip_kind = 3'd1; reg_opnd = 0; od_class = 3'd6; step("R8");
        od_class = 3'd6; ex_class = 3'd5; step("R6");
        pf_empty = 1; step("R6"); pf_empty = 0;
        ex_class = 3'd5; step("R6");
        ex_class = 3'd1; od_class = 3'd0; step("R6");
        step("R6");
        // R7 trap with wait, control flow ignored (R10)
        ex_class = 3'd7; ex_trap_num = 5'd5; od_class = 3'd6; step("R10");
        ex_trap_num = 5'd17; mem_wait = 1; step("R7"); step("R10");
        mem_wait = 0; mem_rdata = 32'h0000_1234; step("R7");
        idle(); ex_class = 3'd7; ex_trap_num = 5'd31; step("R7");
        mem_rdata = 32'hdead_beec; step("R7");
        // R8, R9, R11
        idle(); od_class = 3'd6; ex_class = 3'd1; step("R8");
        pf_empty = 1; step("R9"); irq_req = 1; step("R11");
        pf_empty = 0; irq_num = 5'd9; irq_sw = 1; step("R11");
        irq_sw = 0; irq_num = 5'd3; ex_class = 3'd2; step("R11");
        mem_wait = 1; step("R11"); mem_wait = 0; step("R11");
        // random traffic
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            rst = ($urandom_range(0, 199) == 0);
            od_class = 3'($urandom_range(0, 7));
            ex_class = ($urandom_range(0, 3) == 0) ? 3'd5 : 3'($urandom_range(0, 7));
            ex_skip_kind = 3'($urandom_range(0, 6));
            ex_flag_mask = 4'($urandom_range(0, 15));
            flags = 4'($urandom_range(0, 15));
            reg_opnd = ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom;
            ex_bit_sel = 5'($urandom_range(0, 31));
            ex_trap_num = 5'($urandom_range(0, 31));
            mem_wait = ($urandom_range(0, 9) < 4);
            mem_rdata = $urandom;
            pf_empty = ($urandom_range(0, 9) == 0);
            irq_req = ($urandom_range(0, 9) == 0);
            irq_sw = 1'($urandom_range(0, 1));
            irq_num = 5'($urandom_range(0, 31));
            step(area_tag());
        end
        summary();
    end
endmodule